// File: doc/BRIEF.md
# Modulo 2^n-1 End-Around-Carry Prefix Adder

This block adds two n-bit words modulo 2^n-1 in one combinational pass. It sits at the end of a modular multiplier, after the carry-save tree, and turns the remaining redundant pair (a sum vector and a carry vector) into one residue. Every bit first forms its own generate and propagate. A log-depth prefix tree then combines them into group terms, and the sum bits come from the propagate bits and the carries into each position.

Modulo 2^n-1, a carry out of the top bit weighs 2^n, which is congruent to 1. So the block feeds that carry back in at bit 0. The fold-back costs one extra prefix level that merges the all-bits group generate into every prefix, so no combinational loop forms and no second addition is needed. Zero has two encodings: all zeros, which appears only when both operands are zero, and all ones, which appears for every other zero residue. An optional flag reports an all-ones result. A parameter picks one of two prefix tree shapes.

Top module: `mod_eac_adder`

## Requirements
- R1: When (a_i + b_i) mod (2^WIDTH-1) is nonzero, s_o equals that residue.
- R2: When both a_i and b_i are zero, s_o is all zeros.
- R3: When the residue is zero and at least one operand is nonzero, s_o is all ones. Examples are b_i = ~a_i, and both operands all ones.
- R4: A carry out of bit WIDTH-1 adds one at bit 0. For example, with both operands equal to 2^(WIDTH-1), s_o = 1.
- R5: Swapping a_i and b_i leaves s_o unchanged.
- R6: With EMIT_ONES = 1, ones_o is 1 exactly when s_o is all ones. With EMIT_ONES = 0, ones_o stays 0.
- R7: The two TREE settings (0 = log-stride tree, 1 = divide-and-conquer tree) give identical s_o for every operand pair.
- R8: When a_i is zero, s_o equals b_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (sum vector from the reduction tree) |
| b_i | input | WIDTH | Second operand (carry vector from the reduction tree) |
| s_o | output | WIDTH | Sum modulo 2^WIDTH-1 |
| ones_o | output | 1 | High when s_o is all ones (only when EMIT_ONES = 1) |

## Verification
The hardest case to reach is an operand pair whose bits all propagate and none generate, that is b_i = ~a_i. In that case the folded carry must stay zero, and the result must be the all-ones form of zero rather than a wrapped value. Random operands hit this case with probability 2^-n, so the bench sweeps every pair at eight bits. At sixteen bits it forces the complement pattern on a fixed share of the random vectors, and it also drives the all-ones-plus-all-ones and top-carry corners directly.

// File: rtl/mod_eac_pkg.sv
package mod_eac_pkg;

  typedef enum logic [0:0] {
    TREE_STRIDE = 1'b0,
    TREE_SPLIT  = 1'b1
  } tree_e;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // hi covers the more significant span
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/mod_eac_pregen.sv
module mod_eac_pregen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);

  assign g_o = a_i & b_i;
  assign p_o = a_i ^ b_i;

endmodule

// File: rtl/mod_eac_prefix.sv
module mod_eac_prefix
  import mod_eac_pkg::*;
#(
  parameter int    WIDTH = 16,
  parameter tree_e TREE  = TREE_STRIDE
) (
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] grp_g_o,  // group generate over [i:0]
  output logic [WIDTH-1:0] grp_p_o   // group propagate over [i:0]
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  gp_t [LEVELS:0][WIDTH-1:0] node;

  if (TREE == TREE_STRIDE) begin : g_stride
    always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
        node[0][i].g = g_i[i];
        node[0][i].p = p_i[i];
      end
      for (int lv = 1; lv <= LEVELS; lv++) begin
        for (int i = 0; i < WIDTH; i++) begin
          node[lv][i] = node[lv-1][i];
          if (i >= (1 << (lv - 1)))
            node[lv][i] = gp_merge(node[lv-1][i], node[lv-1][i - (1 << (lv - 1))]);
        end
      end
    end
  end else begin : g_split
    always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
        node[0][i].g = g_i[i];
        node[0][i].p = p_i[i];
      end
      for (int lv = 1; lv <= LEVELS; lv++) begin
        for (int i = 0; i < WIDTH; i++) begin
          node[lv][i] = node[lv-1][i];
          // upper half of each 2^lv block takes the lower half's top prefix
          if (((i >> (lv - 1)) & 1) == 1)
            node[lv][i] = gp_merge(node[lv-1][i],
                                   node[lv-1][((i >> (lv - 1)) << (lv - 1)) - 1]);
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      grp_g_o[i] = node[LEVELS][i].g;
      grp_p_o[i] = node[LEVELS][i].p;
    end
  end

endmodule

// File: rtl/mod_eac_wrap.sv
module mod_eac_wrap #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] grp_g_i,
  input  logic [WIDTH-1:0] grp_p_i,
  output logic [WIDTH-1:0] carry_o   // carry into each bit position
);

  logic             eac;
  logic [WIDTH-1:0] fold;

  // all-bits generate is the wrapped carry; all-propagate implies it is 0
  assign eac  = grp_g_i[WIDTH-1];

  // extra prefix level: every prefix also absorbs the wrapped carry
  assign fold = grp_g_i | (grp_p_i & {WIDTH{eac}});

  assign carry_o = {fold[WIDTH-2:0], fold[WIDTH-1]};

endmodule

// File: rtl/mod_eac_sumgen.sv
module mod_eac_sumgen #(
  parameter bit EMIT_ONES = 1'b1,
  parameter int WIDTH     = 16
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] s_o,
  output logic             ones_o
);

  assign s_o = p_i ^ carry_i;

  if (EMIT_ONES) begin : g_flag
    assign ones_o = &s_o;
  end else begin : g_noflag
    assign ones_o = 1'b0;
  end

endmodule

// File: rtl/mod_eac_adder.sv
module mod_eac_adder
  import mod_eac_pkg::*;
#(
  parameter int    WIDTH     = 16,
  parameter tree_e TREE      = TREE_STRIDE,
  parameter bit    EMIT_ONES = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] s_o,
  output logic             ones_o
);

  logic [WIDTH-1:0] bit_g, bit_p;
  logic [WIDTH-1:0] grp_g, grp_p;
  logic [WIDTH-1:0] carry;

  mod_eac_pregen #(.WIDTH(WIDTH)) pregen_i (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (bit_g),
    .p_o (bit_p)
  );

  mod_eac_prefix #(.WIDTH(WIDTH), .TREE(TREE)) prefix_i (
    .g_i     (bit_g),
    .p_i     (bit_p),
    .grp_g_o (grp_g),
    .grp_p_o (grp_p)
  );

  mod_eac_wrap #(.WIDTH(WIDTH)) wrap_i (
    .grp_g_i (grp_g),
    .grp_p_i (grp_p),
    .carry_o (carry)
  );

  mod_eac_sumgen #(.EMIT_ONES(EMIT_ONES), .WIDTH(WIDTH)) sumgen_i (
    .p_i     (bit_p),
    .carry_i (carry),
    .s_o     (s_o),
    .ones_o  (ones_o)
  );

endmodule

// File: rtl/mod_eac_adder_chk.sv
module mod_eac_adder_chk #(
  parameter int WIDTH     = 16,
  parameter bit EMIT_ONES = 1'b1
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] s_o,
  input logic             ones_o
);

  localparam logic [WIDTH:0] MODV = {1'b0, {WIDTH{1'b1}}};

  logic [WIDTH:0] wide_sum;
  logic [WIDTH:0] resid;

  always_comb begin
    wide_sum = {1'b0, a_i} + {1'b0, b_i};
    resid    = wide_sum % MODV;
    if (!$isunknown({a_i, b_i, s_o, ones_o})) begin
      // R1
      residue_chk: assert (resid == '0 || s_o == resid[WIDTH-1:0]);
      // R2
      zero_in_zero_out_chk: assert (!(a_i == '0 && b_i == '0) || s_o == '0);
      // R3
      ones_zero_chk: assert (resid != '0 || (a_i == '0 && b_i == '0) || (&s_o));
      // R8
      identity_chk: assert (a_i != '0 || s_o == b_i);
      // R6
      ones_flag_chk: assert (ones_o == (EMIT_ONES ? (&s_o) : 1'b0));
    end
  end

endmodule

bind mod_eac_adder mod_eac_adder_chk #(.WIDTH(WIDTH), .EMIT_ONES(EMIT_ONES)) chk_i (
  .a_i    (a_i),
  .b_i    (b_i),
  .s_o    (s_o),
  .ones_o (ones_o)
);

// File: tb/mod_eac_adder_tb_top.sv
module mod_eac_adder_tb_top;
  import mod_eac_pkg::*;

  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4ns clk = ~clk;

  logic [7:0]  a8 = '0, b8 = '0, s8, s8_split;
  logic        ones8, ones8_split;
  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        ones16;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  mod_eac_adder #(.WIDTH(8), .TREE(TREE_STRIDE), .EMIT_ONES(1'b1)) dut_i (
    .a_i(a8), .b_i(b8), .s_o(s8), .ones_o(ones8));

  mod_eac_adder #(.WIDTH(8), .TREE(TREE_SPLIT), .EMIT_ONES(1'b0)) dut_split_i (
    .a_i(a8), .b_i(b8), .s_o(s8_split), .ones_o(ones8_split));

  mod_eac_adder #(.WIDTH(16), .TREE(TREE_STRIDE), .EMIT_ONES(1'b1)) dut_w16_i (
    .a_i(a16), .b_i(b16), .s_o(s16), .ones_o(ones16));

  function automatic longint ref_sum(input longint a, input longint b, input int w);
    longint m = (longint'(1) << w) - 1;
    longint r = (a + b) % m;
    if (r == 0 && (a != 0 || b != 0)) r = m;
    return r;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b);
    @(posedge clk);
    a16 = a;
    b16 = b;
    @(negedge clk);
  endtask

  initial begin
    #(8ns * WD_CYCLES);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // reset phase: operands zero
    repeat (3) @(negedge clk);
    chk("R2", "reset zero", longint'(s8), 0);
    chk("R6", "reset flag", longint'(ones8), 0);
    rst_ni = 1'b1;

    // exhaustive 8-bit sweep
    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 256; bi++) begin
        longint e;
        string  tag;
        @(posedge clk);
        a8 = 8'(ai);
        b8 = 8'(bi);
        @(negedge clk);
        e = ref_sum(ai, bi, 8);
        if (ai == 0 && bi == 0) tag = "R2";
        else if (e == 255)      tag = "R3";
        else                    tag = "R1";
        chk(tag, $sformatf("w8 %0h+%0h", ai, bi), longint'(s8), e);
        if (ai == 0) chk("R8", "w8 identity", longint'(s8), longint'(bi));
        chk("R6", "w8 flag", longint'(ones8), longint'(e == 255));
        chk("R7", "split tree", longint'(s8_split), longint'(s8));
        chk("R6", "flag off", longint'(ones8_split), 0);
      end
    end

    // 16-bit corners: wrapped carry (R4), double-ones and complement (R3)
    drive16(16'h8000, 16'h8000);
    chk("R4", "top carry wraps", longint'(s16), 1);
    drive16(16'hFFFF, 16'h0001);
    chk("R4", "ones plus one", longint'(s16), 1);
    drive16(16'hC000, 16'h4001);
    chk("R4", "carry into bit0", longint'(s16), 2);
    drive16(16'hFFFF, 16'hFFFF);
    chk("R3", "ones plus ones", longint'(s16), 16'hFFFF);
    chk("R6", "w16 flag ones", longint'(ones16), 1);
    drive16(16'hA5C3, 16'h5A3C);
    chk("R3", "complement pair", longint'(s16), 16'hFFFF);
    drive16(16'h0000, 16'h0000);
    chk("R2", "w16 zero", longint'(s16), 0);
    chk("R6", "w16 flag zero", longint'(ones16), 0);

    // 16-bit random with forced complement share
    for (int k = 0; k < 20000; k++) begin
      logic [15:0] ra, rb;
      longint e;
      ra = 16'($urandom);
      rb = (k % 8 == 0) ? ~ra : 16'($urandom);
      drive16(ra, rb);
      e = ref_sum(longint'(ra), longint'(rb), 16);
      chk((e == 16'hFFFF) ? "R3" : "R1", $sformatf("w16 %0h+%0h", ra, rb), longint'(s16), e);
      chk("R6", "w16 flag", longint'(ones16), longint'(e == 16'hFFFF));
    end

    // commutativity
    for (int k = 0; k < 2000; k++) begin
      logic [15:0] ra, rb;
      longint first;
      ra = 16'($urandom);
      rb = 16'($urandom);
      drive16(ra, rb);
      first = longint'(s16);
      drive16(rb, ra);
      chk("R5", $sformatf("swap %0h,%0h", ra, rb), longint'(s16), first);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule